// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs external memory cycles for an 8-bit microcontroller core over a pair of ports. The core hands it one request at a time: an instruction fetch, a data access through a full 16-bit pointer, or a data access through an 8-bit register-indirect address. The block then drives the multiplexed low port (address low byte, then data), the high port, the address latch enable and three active-low strobes. A fetch uses only the program-store strobe, and data accesses use only the read or write strobe. After each cycle it returns a response to the core.

The block also owns the two port latch registers. Every accepted access overwrites the low-port latch with all ones. A 16-bit access shows its high address byte on the high port and leaves the high-port latch untouched. An 8-bit access lets the high-port latch contents stay on the pins, so the core can select a 256-byte page by writing that latch.

Requests use valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Responses also use valid/ready. The core may hold `rsp_ready` low for as long as it likes. While it does, `rsp_valid` and `rsp_rdata` stay frozen and no new request is taken. The SFR write ports and the pin signals carry no handshake.

Top module: `xbus_ctrl`

## Requirements
- R1: During the strobe window only one strobe is low. A fetch (`req_kind`=00) lowers only `psen_n`, and always reads even if `req_write` is 1. A data access (`req_kind`=01 or 1x) lowers only `rd_n` (when `req_write`=0) or only `wr_n` (when `req_write`=1). All strobes are high outside the window.
- R2: `rsp_rdata` of a read or fetch equals `lo_in` as sampled on the clock edge that ends the last strobe cycle. For a write it is 0.
- R3: After acceptance, `ale` is high for ALE_CYC cycles, followed by one cycle with `ale` low. In all of these cycles `lo_oe`=1 and `lo_out` carries address bits [7:0]. Only then does the strobe window of STB_CYC cycles begin.
- R4: In a write, `lo_oe`=1 and `lo_out` equals the write byte for the whole strobe window and for one cycle after it.
- R5: In a 16-bit access (`req_kind` 00 or 01), `hi_out` shows address bits [15:8] from the cycle after acceptance through the cycle after the strobe window. `sfr_hi_q` is not changed by the access.
- R6: In an 8-bit access (`req_kind` 1x), `hi_out` equals `sfr_hi_q` in every cycle, including after a core write to that latch during the access. Address bits [15:8] are ignored.
- R7: `sfr_lo_q` becomes 0xFF on every acceptance edge, even if `sfr_lo_we` is high on the same edge. Otherwise `sfr_lo_we` loads `sfr_wdata`.
- R8: `lo_oe` is 0 while idle, during the strobe window and recovery cycle of a read, and while a response waits.
- R9: `hi_strong` equals the high address byte (1 bits driven strongly) for the whole R5 window of a 16-bit access, and is 0 at all other times.
- R10: `req_ready` is high exactly when idle, and requests offered while busy have no effect. `rsp_valid` rises in the cycle after the recovery cycle and stays high with stable `rsp_rdata` until taken with `rsp_ready`. The block is idle in the next cycle. `busy` is high from acceptance until then.
- R11: Under reset, all strobes are high, `ale`=0, `lo_oe`=0, `rsp_valid`=0, `req_ready`=1, and both latches read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this edge if valid |
| req_kind | input | 2 | 00 fetch, 01 16-bit data, 1x 8-bit data |
| req_write | input | 1 | Data write when 1 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Core takes response |
| rsp_rdata | output | 8 | Read byte, 0 for writes |
| busy | output | 1 | Access in progress or response pending |
| sfr_lo_we | input | 1 | Core write to low-port latch |
| sfr_hi_we | input | 1 | Core write to high-port latch |
| sfr_wdata | input | 8 | Latch write byte |
| sfr_lo_q | output | 8 | Low-port latch |
| sfr_hi_q | output | 8 | High-port latch |
| lo_out | output | 8 | Low-port drive value |
| lo_oe | output | 1 | Low-port push-pull enable |
| lo_in | input | 8 | Low-port pin value |
| hi_out | output | 8 | High-port drive value |
| hi_strong | output | 8 | Per-bit strong pull-up on high port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store read strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |

## Verification
All results are timed from the acceptance edge. With defaults A=2 and S=3:
- `ale` is high in cycles 1 and 2 after acceptance.
- Cycle 3 holds the address with `ale` low.
- The strobe is low in cycles 4 to 6, and `lo_in` is captured on the edge ending cycle 6.
- Write data and the high byte remain through cycle 7.
- `rsp_valid` appears in cycle 8 and lasts until the edge where `rsp_ready` is seen.

The latch writes take effect one edge after they are driven. The bench keeps an elapsed-cycle count per access and derives every expected pin value from it. It compares all outputs at each falling edge, after the rising edge has settled and before new inputs are driven.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV,
    PH_RESP
  } phase_t;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WIDE  = 2'b01;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ALE_CYC = 2,
  parameter int STB_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic                req_write,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                rsp_ready,
  output phase_t              phase,
  output logic                accept,
  output logic                last_strobe,
  output logic                cur_fetch,
  output logic                cur_paged,
  output logic                cur_write,
  output logic [2*DATA_W-1:0] cur_addr,
  output logic [DATA_W-1:0]   cur_wdata
);
  localparam int CMAX  = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYC - 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign accept      = req_valid && (phase == PH_IDLE);
  assign last_strobe = (phase == PH_STROBE) && (cnt == STB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_fetch <= 1'b0;
      cur_paged <= 1'b0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase     <= PH_ADDR;
          cnt       <= '0;
          cur_fetch <= (req_kind == KIND_FETCH);
          cur_paged <= req_kind[1];
          cur_write <= req_write && (req_kind != KIND_FETCH);
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
        end
        PH_ADDR: begin
          if (cnt == ALE_LAST) phase <= PH_SETUP;
          else cnt <= cnt + 1'b1;
        end
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= '0;
        end
        PH_STROBE: begin
          if (cnt == STB_LAST) phase <= PH_RECOV;
          else cnt <= cnt + 1'b1;
        end
        PH_RECOV: phase <= PH_RESP;
        PH_RESP: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_lo_port.sv
module xbus_lo_port
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              accept,
  input  logic              last_strobe,
  input  logic              is_write,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sfr_we,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] lo_in,
  output logic [DATA_W-1:0] sfr_q,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [DATA_W-1:0] rdata
);
  logic addr_phase, data_phase;

  assign addr_phase = (phase == PH_ADDR) || (phase == PH_SETUP);
  assign data_phase = (phase == PH_STROBE) || (phase == PH_RECOV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfr_q <= '1;
      rdata <= '0;
    end else begin
      if (accept)      sfr_q <= '1;
      else if (sfr_we) sfr_q <= sfr_wdata;
      if (accept)                       rdata <= '0;
      else if (last_strobe && !is_write) rdata <= lo_in;
    end
  end

  always_comb begin
    lo_oe  = addr_phase || (is_write && data_phase);
    lo_out = sfr_q;
    if (addr_phase)                   lo_out = addr_lo;
    else if (is_write && data_phase) lo_out = wdata;
  end
endmodule

// File: rtl/xbus_hi_port.sv
module xbus_hi_port
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              paged,
  input  logic [DATA_W-1:0] addr_hi,
  input  logic              sfr_we,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_q,
  output logic [DATA_W-1:0] hi_out,
  output logic [DATA_W-1:0] hi_strong
);
  logic addr_owned;

  assign addr_owned = !paged && (phase inside {PH_ADDR, PH_SETUP, PH_STROBE, PH_RECOV});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sfr_q <= '1;
    else if (sfr_we) sfr_q <= sfr_wdata;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign hi_out[b]    = addr_owned ? addr_hi[b] : sfr_q[b];
    assign hi_strong[b] = addr_owned && addr_hi[b];
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ALE_CYC = 2,
  parameter int STB_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic                req_write,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                busy,
  input  logic                sfr_lo_we,
  input  logic                sfr_hi_we,
  input  logic [DATA_W-1:0]   sfr_wdata,
  output logic [DATA_W-1:0]   sfr_lo_q,
  output logic [DATA_W-1:0]   sfr_hi_q,
  output logic [DATA_W-1:0]   lo_out,
  output logic                lo_oe,
  input  logic [DATA_W-1:0]   lo_in,
  output logic [DATA_W-1:0]   hi_out,
  output logic [DATA_W-1:0]   hi_strong,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n
);
  localparam int ADDR_W = 2 * DATA_W;

  phase_t              phase;
  logic                accept, last_strobe;
  logic                cur_fetch, cur_paged, cur_write;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DATA_W-1:0]   cur_wdata;
  logic                strobe_on;

  xbus_seq #(.DATA_W(DATA_W), .ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)) i_seq (
    .clk, .rst_n, .req_valid, .req_kind, .req_write, .req_addr, .req_wdata,
    .rsp_ready, .phase, .accept, .last_strobe, .cur_fetch, .cur_paged,
    .cur_write, .cur_addr, .cur_wdata
  );

  xbus_lo_port #(.DATA_W(DATA_W)) i_lo (
    .clk, .rst_n, .phase, .accept, .last_strobe, .is_write(cur_write),
    .addr_lo(cur_addr[DATA_W-1:0]), .wdata(cur_wdata), .sfr_we(sfr_lo_we),
    .sfr_wdata, .lo_in, .sfr_q(sfr_lo_q), .lo_out, .lo_oe, .rdata(rsp_rdata)
  );

  xbus_hi_port #(.DATA_W(DATA_W)) i_hi (
    .clk, .rst_n, .phase, .paged(cur_paged), .addr_hi(cur_addr[ADDR_W-1:DATA_W]),
    .sfr_we(sfr_hi_we), .sfr_wdata, .sfr_q(sfr_hi_q), .hi_out, .hi_strong
  );

  assign strobe_on = (phase == PH_STROBE);
  assign req_ready = (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign rsp_valid = (phase == PH_RESP);
  assign ale       = (phase == PH_ADDR);
  assign psen_n    = !(strobe_on && cur_fetch);
  assign rd_n      = !(strobe_on && !cur_fetch && !cur_write);
  assign wr_n      = !(strobe_on && !cur_fetch && cur_write);
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              busy,
  input logic [DATA_W-1:0] sfr_lo_q,
  input logic [DATA_W-1:0] lo_out,
  input logic              lo_oe,
  input logic [DATA_W-1:0] hi_out,
  input logic [DATA_W-1:0] hi_strong,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n
);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  a_r3_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n && lo_oe));

  a_r3_addr_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (lo_oe && $stable(lo_out)));

  a_r4_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (lo_oe && $stable(lo_out)));

  a_r7_latch_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (sfr_lo_q == '1));

  a_r8_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lo_oe);

  a_r9_strong_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_strong & ~hi_out) == '0));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !rsp_valid));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .busy(busy), .sfr_lo_q(sfr_lo_q), .lo_out(lo_out), .lo_oe(lo_oe),
  .hi_out(hi_out), .hi_strong(hi_strong), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  localparam int A = 2;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b0, busy;
  logic [7:0] rsp_rdata;
  logic sfr_lo_we = 1'b0, sfr_hi_we = 1'b0;
  logic [7:0] sfr_wdata = '0, sfr_lo_q, sfr_hi_q, lo_out, lo_in = '0, hi_out, hi_strong;
  logic lo_oe, ale, psen_n, rd_n, wr_n;

  int n_chk = 0, n_err = 0;

  always #4ns clk = ~clk;

  xbus_ctrl #(.DATA_W(8), .ALE_CYC(A), .STB_CYC(S)) i_xbus_ctrl (.*);

  // reference model state
  logic m_busy = 1'b0, m_wr = 1'b0;
  int t = 0;
  logic [1:0] m_kind = '0;
  logic [15:0] m_addr = '0;
  logic [7:0] m_wd = '0, m_rd = '0, m_lo = 8'hFF, m_hi = 8'hFF;
  logic [31:0] rng = 32'h1234_5678;

  logic [1:0]  fx_kind [10] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd3, 2'd1, 2'd0, 2'd1};
  logic        fx_wr   [10] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  logic [15:0] fx_addr [10] = '{16'h12A5, 16'hFFFF, 16'h8001, 16'h0033, 16'hABC4,
                                16'h0000, 16'h5566, 16'h00FF, 16'hF00F, 16'h7E81};
  logic [7:0]  fx_wd   [10] = '{8'h00, 8'h00, 8'h5A, 8'h00, 8'hA5,
                                8'h77, 8'h00, 8'hFF, 8'h00, 8'h00};
  int fx_idx = 0;

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic stb, win, wide, e_oe;
    stb  = m_busy && t >= A + 2 && t <= A + 1 + S;
    win  = m_busy && t <= A + S + 2;
    wide = !m_kind[1];
    e_oe = m_busy && (t <= A + 1 || (m_wr && t <= A + S + 2));
    chk("R10", "req_ready", req_ready, !m_busy);
    chk("R10", "busy", busy, m_busy);
    chk("R10", "rsp_valid", rsp_valid, m_busy && t >= A + S + 3);
    chk("R3", "ale", ale, m_busy && t <= A);
    chk("R1", "psen_n", psen_n, !(stb && m_kind == 2'd0));
    chk("R1", "rd_n", rd_n, !(stb && m_kind != 2'd0 && !m_wr));
    chk("R1", "wr_n", wr_n, !(stb && m_kind != 2'd0 && m_wr));
    chk("R8", "lo_oe", lo_oe, e_oe);
    if (m_busy && t <= A + 1) chk("R3", "lo_out addr", lo_out, m_addr[7:0]);
    else if (e_oe)            chk("R4", "lo_out wdata", lo_out, m_wd);
    if (win && wide) chk("R5", "hi_out", hi_out, m_addr[15:8]);
    else             chk("R6", "hi_out", hi_out, m_hi);
    chk("R9", "hi_strong", hi_strong, (win && wide) ? m_addr[15:8] : 8'h00);
    chk("R5", "sfr_hi_q", sfr_hi_q, m_hi);
    chk("R7", "sfr_lo_q", sfr_lo_q, m_lo);
    if (m_busy && t >= A + S + 3) chk("R2", "rsp_rdata", rsp_rdata, m_rd);
  endtask

  task automatic drive();
    rng = nxt(rng);
    rsp_ready = rng[0];
    lo_in     = rng[15:8];
    sfr_lo_we = (rng[18:16] == 3'd0);
    sfr_hi_we = (rng[21:19] == 3'd0);
    sfr_wdata = rng[29:22];
    if (!m_busy) begin
      req_valid = (rng[31:30] != 2'd0);
      if (fx_idx < 10) begin
        req_kind = fx_kind[fx_idx]; req_write = fx_wr[fx_idx];
        req_addr = fx_addr[fx_idx]; req_wdata = fx_wd[fx_idx];
        if (req_valid) fx_idx++;
      end else begin
        rng = nxt(rng);
        req_kind = 2'(rng[1:0] % 3); req_write = rng[2];
        req_addr = rng[31:16]; req_wdata = rng[15:8];
      end
    end else begin
      // offers while busy must be ignored (R10)
      req_valid = rng[30];
      req_kind = rng[5:4]; req_write = rng[6]; req_addr = rng[31:16]; req_wdata = rng[7:0];
    end
  endtask

  task automatic step();
    logic acc;
    acc = !m_busy && req_valid;
    if (acc) begin
      m_busy = 1'b1; t = 1; m_kind = req_kind;
      m_wr = req_write && req_kind != 2'd0;
      m_addr = req_addr; m_wd = req_wdata; m_rd = 8'h00;
    end else if (m_busy) begin
      if (t == A + 1 + S && !m_wr) m_rd = lo_in;
      if (t >= A + S + 3) begin
        if (rsp_ready) m_busy = 1'b0;
      end else t++;
    end
    if (acc)            m_lo = 8'hFF;
    else if (sfr_lo_we) m_lo = sfr_wdata;
    if (sfr_hi_we)      m_hi = sfr_wdata;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R11", "psen_n", psen_n, 1); chk("R11", "rd_n", rd_n, 1);
      chk("R11", "wr_n", wr_n, 1);     chk("R11", "ale", ale, 0);
      chk("R11", "lo_oe", lo_oe, 0);   chk("R11", "rsp_valid", rsp_valid, 0);
      chk("R11", "req_ready", req_ready, 1);
      chk("R11", "sfr_lo_q", sfr_lo_q, 8'hFF); chk("R11", "sfr_hi_q", sfr_hi_q, 8'hFF);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      compare();
      drive();
      step();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200us;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule